// File: doc/BRIEF.md
# Scanline Sprite Evaluation Scanner

This block finds the sprites that appear on the next video line. It works only after the background tile engines have finished with the shared video memory. They signal this with a one-cycle start pulse. The scanner then reads a 64-entry sprite attribute table in index order, one entry per clock, through a read port with no latency. It compares the vertical position of each entry with the current line number.

Each entry that covers the line is presented downstream as one record. The record carries the raw 32-bit attribute word and the pixel row inside the sprite that the line falls on. The record is held on a valid/halt handshake. The downstream fetch manager raises halt while it reads pattern data, and the scanner then freezes in place. Scanning ends after the sixteenth delivered record or after the last table entry has been examined. A done flag then stays high until the next start pulse.

The controller has four states. IDLE is the state after reset. SCAN examines one entry per cycle. EMIT presents a matching record. DONE means the line is finished. The transitions are as follows:
- start: IDLE or DONE to SCAN.
- hit: SCAN to EMIT.
- advance: SCAN to SCAN, on a miss before the last entry.
- exhaust: SCAN to DONE, on a miss at the last entry.
- stall: EMIT to EMIT, while halt is high.
- resume: EMIT to SCAN, when a record is accepted before the cap and before the last entry.
- finish: EMIT to DONE, when the accepted record is the sixteenth or comes from the last entry.

Top module: `sprite_line_scanner`

## Requirements
- R1: After reset, valid_o and done_o are low and oam_addr_o is 0.
- R2: A start_i pulse seen in IDLE or DONE clears done_o and begins a scan at entry 0 on the next cycle. Scanning never begins without such a pulse.
- R3: An entry matches when its Y byte (bits 31:24) satisfies 0 <= line_i - Y < 8, computed without wrap-around. For example, Y=250 does not match line 3.
- R4: Matching entries are delivered in increasing table index. rec_o equals the entry word exactly (Y 31:24, tile 23:16, flags 15:8, X 7:0). A record is accepted on a clock edge where valid_o is high and halt_i is low.
- R5: row_o is line_i - Y. When flag bit 7 (vertical flip, word bit 15) is set, row_o is 7 - (line_i - Y).
- R6: At most 16 records are delivered per scan. done_o rises in the cycle after the sixteenth is accepted.
- R7: While valid_o and halt_i are high, rec_o, row_o, valid_o and oam_addr_o hold their values on the next cycle.
- R8: Entry 63 is examined like every other entry. If it matches, it is delivered and done_o rises in the cycle after its acceptance.
- R9: With no cap reached, done_o rises once entry 63 has been checked. With no matches at all, this is 65 cycles after the start edge. done_o stays high until the next start pulse.
- R10: A start_i pulse during a scan is ignored: the index is not reset and the delivered sequence is unchanged.
- R11: valid_o and done_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Tile engines have released video memory; begin a scan |
| line_i | input | 8 | Line number about to be drawn |
| oam_addr_o | output | 6 | Attribute table read index |
| oam_data_i | input | 32 | Attribute word at oam_addr_o, same cycle |
| halt_i | input | 1 | Downstream busy; freeze the scanner |
| rec_o | output | 32 | Matching attribute word |
| row_o | output | 3 | Row within the sprite, flip applied |
| valid_o | output | 1 | rec_o/row_o hold a record to deliver |
| done_o | output | 1 | Scan of this line finished |

## Verification
Two events can fall on the same edge: a stall from halt_i, and the final acceptance that ends the scan, either the sixteenth record or a match at entry 63. The bench drives a pseudo-random halt pattern during scans where the cap is reached and where the last entry matches. This puts the terminating record in a stalled state for several cycles before its release. The bench judges three things: the record stays frozen while stalled, done_o rises exactly one cycle after the actual acceptance and never alongside valid_o, and no extra record appears. A start pulse sent in the middle of a scan is judged by the index not returning to zero and by the scoreboard order staying intact.

// File: rtl/sprite_scan_pkg.sv
package sprite_scan_pkg;

    localparam int COORD_W   = 8;
    localparam int VFLIP_BIT = 7;

    typedef struct packed {
        logic [COORD_W-1:0] ypos;
        logic [7:0]         tile;
        logic [7:0]         flags;
        logic [COORD_W-1:0] xpos;
    } oam_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_EMIT,
        ST_DONE
    } scan_state_t;

endpackage

// File: rtl/sprite_row_match.sv
module sprite_row_match
    import sprite_scan_pkg::*;
#(
    parameter int SPR_H = 8,
    localparam int ROW_W = (SPR_H > 1) ? $clog2(SPR_H) : 1
) (
    input  logic [COORD_W-1:0] line,
    input  logic [COORD_W-1:0] ypos,
    input  logic               vflip,
    output logic               hit,
    output logic [ROW_W-1:0]   row
);

    logic [COORD_W:0]   diff;
    logic [COORD_W-1:0] span;

    always_comb begin
        diff = {1'b0, line} - {1'b0, ypos};
        span = diff[COORD_W-1:0];
        // borrow set means the sprite starts below this line
        hit  = !diff[COORD_W] && (span < COORD_W'(SPR_H));
        row  = vflip ? ROW_W'(SPR_H - 1) - span[ROW_W-1:0] : span[ROW_W-1:0];
    end

endmodule

// File: rtl/sprite_hit_counter.sv
module sprite_hit_counter #(
    parameter int MAX_HITS = 16,
    localparam int CNT_W = $clog2(MAX_HITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_cap_next
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign at_cap_next = (count_q == CNT_W'(MAX_HITS - 1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(MAX_HITS));

endmodule

// File: rtl/sprite_line_scanner.sv
module sprite_line_scanner
    import sprite_scan_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int MAX_HITS = 16,
    parameter int SPR_H    = 8,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int ROW_W = (SPR_H > 1) ? $clog2(SPR_H) : 1,
    localparam int WORD_W = $bits(oam_entry_t)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [COORD_W-1:0] line_i,
    output logic [IDX_W-1:0]   oam_addr_o,
    input  logic [WORD_W-1:0]  oam_data_i,
    input  logic               halt_i,
    output logic [WORD_W-1:0]  rec_o,
    output logic [ROW_W-1:0]   row_o,
    output logic               valid_o,
    output logic               done_o
);

    scan_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    oam_entry_t       rec_q;
    logic [ROW_W-1:0] row_q;
    oam_entry_t       entry;
    logic             hit;
    logic [ROW_W-1:0] row_calc;
    logic             load, cnt_clr, cnt_inc, cap_next, last_entry;

    assign entry      = oam_entry_t'(oam_data_i);
    assign last_entry = (idx_q == IDX_W'(ENTRIES - 1));

    sprite_row_match #(.SPR_H(SPR_H)) u_match (
        .line  (line_i),
        .ypos  (entry.ypos),
        .vflip (entry.flags[VFLIP_BIT]),
        .hit   (hit),
        .row   (row_calc)
    );

    sprite_hit_counter #(.MAX_HITS(MAX_HITS)) u_hits (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cnt_clr),
        .inc         (cnt_inc),
        .at_cap_next (cap_next)
    );

    // next-state and control
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        load    = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_SCAN;
                    idx_d   = '0;
                    cnt_clr = 1'b1;
                end
            end
            ST_SCAN: begin
                if (hit) begin
                    state_d = ST_EMIT;
                    load    = 1'b1;
                end else if (last_entry) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_EMIT: begin
                if (!halt_i) begin
                    cnt_inc = 1'b1;
                    if (cap_next || last_entry) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_SCAN;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rec_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (load) begin
                rec_q <= entry;
                row_q <= row_calc;
            end
        end
    end

    // outputs
    always_comb begin
        valid_o    = (state_q == ST_EMIT);
        done_o     = (state_q == ST_DONE);
        oam_addr_o = idx_q;
        rec_o      = rec_q;
        row_o      = row_q;
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && halt_i) |=> (valid_o && $stable(rec_o) && $stable(row_o) && $stable(oam_addr_o)));

    // R2
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_DONE) && start_i) |=> (oam_addr_o == '0 && !done_o));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && start_i && oam_addr_o != '0) |=> (oam_addr_o != '0));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

// File: tb/sprite_line_scanner_bench.sv
module sprite_line_scanner_bench;

    typedef struct {
        logic [31:0] rec;
        logic [2:0]  row;
        int          idx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  line_i = '0;
    logic [5:0]  oam_addr_o;
    logic [31:0] oam_data_i;
    logic        halt_i = 1'b0;
    logic [31:0] rec_o;
    logic [2:0]  row_o;
    logic        valid_o;
    logic        done_o;

    logic [31:0] oam [64];
    exp_t        sb_q [$];
    int n_chk = 0;
    int n_fail = 0;
    int emitted = 0;
    bit halt_en = 1'b0;
    bit pending_done = 1'b0;
    bit stall_prev = 1'b0;
    logic [31:0] prev_rec;
    logic [2:0]  prev_row;
    logic [5:0]  prev_addr;
    logic [7:0]  lfsr = 8'hA5;
    int cyc = 0;

    always #2 clk = ~clk;

    assign oam_data_i = oam[oam_addr_o];

    sprite_line_scanner u_sprite_line_scanner (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .line_i     (line_i),
        .oam_addr_o (oam_addr_o),
        .oam_data_i (oam_data_i),
        .halt_i     (halt_i),
        .rec_o      (rec_o),
        .row_o      (row_o),
        .valid_o    (valid_o),
        .done_o     (done_o)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int y, int tile, bit flip, int x);
        return {8'(y), 8'(tile), flip, 7'h05, 8'(x)};
    endfunction

    task automatic clear_table();
        for (int i = 0; i < 64; i++) oam[i] = mk(200, i, 1'b0, i * 3);
    endtask

    // driver side of the scoreboard: model R3, R5, R6 from the requirements
    task automatic build_expected(int line);
        sb_q.delete();
        for (int i = 0; i < 64; i++) begin
            int d;
            exp_t e;
            d = line - int'(oam[i][31:24]);
            if (d >= 0 && d < 8 && sb_q.size() < 16) begin
                e.rec = oam[i];
                e.row = oam[i][15] ? 3'(7 - d) : 3'(d);
                e.idx = i;
                sb_q.push_back(e);
            end
        end
    endtask

    task automatic run_scan(int line, bit midstart, string tag);
        int guard;
        line_i = 8'(line);
        build_expected(line);
        emitted = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (midstart) begin
            while (oam_addr_o < 6'd5) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            chk(oam_addr_o != 6'd0, "R10", "index after mid-scan start", 64'(oam_addr_o), 64'd5);
        end
        guard = 0;
        while (!done_o && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(done_o, "R9", {tag, " done reached and held"}, 64'(done_o), 64'd1);
        chk(sb_q.size() == 0, "R4", {tag, " records left undelivered"}, 64'(sb_q.size()), 64'd0);
    endtask

    // monitor side of the scoreboard; also owns the halt pattern
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            stall_prev = 1'b0;
            pending_done = 1'b0;
        end else begin
            if (pending_done) begin
                chk(done_o && !valid_o, "R6", "done one cycle after final acceptance (R8)", 64'(done_o), 64'd1);
                pending_done = 1'b0;
            end
            if (stall_prev) begin
                chk(valid_o && rec_o == prev_rec && row_o == prev_row && oam_addr_o == prev_addr,
                    "R7", "record frozen under halt", 64'(rec_o), 64'(prev_rec));
            end
            if (valid_o && done_o) chk(1'b0, "R11", "valid with done", 64'd1, 64'd0);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            halt_i = halt_en & lfsr[0];
            if (valid_o && !halt_i) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected record", 64'(rec_o), 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rec_o == e.rec, "R4", "record word in order", 64'(rec_o), 64'(e.rec));
                    chk(row_o == e.row, "R5", "row offset", 64'(row_o), 64'(e.row));
                    emitted++;
                    if (emitted == 16 || e.idx == 63) pending_done = 1'b1;
                end
            end
            stall_prev = valid_o && halt_i;
            prev_rec = rec_o;
            prev_row = row_o;
            prev_addr = oam_addr_o;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        clear_table();
        repeat (3) @(negedge clk);
        chk(!valid_o && !done_o && oam_addr_o == 0, "R1", "reset state",
            {valid_o, done_o, oam_addr_o}, 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!valid_o && !done_o && oam_addr_o == 0, "R2", "no scan without start",
            {valid_o, done_o, oam_addr_o}, 64'd0);

        // Scene A: Y bounds around line 20, flip, last entry matching (R3 R5 R8)
        oam[0]  = mk(12, 1, 1'b0, 10);
        oam[3]  = mk(13, 2, 1'b0, 20);
        oam[7]  = mk(20, 3, 1'b1, 30);
        oam[12] = mk(21, 4, 1'b0, 40);
        oam[40] = mk(17, 5, 1'b1, 50);
        oam[63] = mk(15, 6, 1'b0, 60);
        run_scan(20, 1'b0, "A");

        // Scene A again with halt pressure on the last-entry finish (R7 R8)
        halt_en = 1'b1;
        run_scan(20, 1'b0, "A-halt");

        // Scene B: 20 matches, cap at 16, start pulse mid-scan (R6 R10)
        clear_table();
        for (int i = 10; i < 30; i++) oam[i] = mk(50 - (i % 8), i, i[0], i);
        run_scan(50, 1'b1, "B");
        halt_en = 1'b0;

        // Scene C: no wrap-around at the top of the screen (R3)
        clear_table();
        oam[0]  = mk(3, 7, 1'b0, 1);
        oam[5]  = mk(250, 8, 1'b0, 2);
        oam[6]  = mk(0, 9, 1'b1, 3);
        oam[63] = mk(255, 10, 1'b0, 4);
        run_scan(3, 1'b0, "C");

        // Scene D: no matches, done after full table walk (R9)
        clear_table();
        line_i = 8'd100;
        build_expected(100);
        @(negedge clk); start_i = 1'b1;
        n = 0;
        @(negedge clk); start_i = 1'b0; n = 1;
        while (!done_o && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(n == 65, "R9", "cycles to done with no matches", 64'(n), 64'd65);
        repeat (5) @(negedge clk);
        chk(done_o && !valid_o, "R9", "done held until next start", 64'(done_o), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule